// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Decimal Adjust

This block is the data-path heart of a small accumulator machine. Each cycle it receives the accumulator value, a second operand, the current status flags and a four-bit operation code. It produces the new accumulator value and the new status flags (sign, zero, auxiliary carry, parity, carry). The operation set covers binary addition and subtraction, each with or without the incoming carry. It also covers the three bitwise operations, compare, accumulator complement, carry set and carry complement, the four one-bit rotates and a packed-BCD correction step.

The result is formed combinationally. A parameter chooses whether the accumulator and flag outputs are taken straight from that logic or held in output registers behind a synchronous, active-high reset. Flags that an operation does not touch pass from the flag input to the flag output unchanged. The surrounding core can therefore always write the flag output back into its status register.

Top module: `acc_alu`

## Requirements
- R1: Operation codes on `op_i` are ADD=0, ADC=1, SUB=2, SBB=3, AND=4, OR=5, XOR=6, CMP=7, CMA=8, STC=9, CMC=10, RLC=11, RRC=12, RAL=13, RAR=14, DAA=15. Flag vectors are ordered {S,Z,AC,P,CY} from bit 4 down to bit 0. ADD returns A+B. ADC returns A+B+CY. For both, CY is the carry out of the top bit and AC is the carry out of bit 3.
- R2: SUB returns A−B and SBB returns A−B−CY. CY is set when B plus the borrow-in exceeds A as unsigned numbers. AC is set on a borrow out of the low nibble.
- R3: CMP sets S, Z, AC, P and CY exactly as SUB would. The accumulator output equals the accumulator input.
- R4: AND, OR and XOR return the bitwise result and clear both CY and AC.
- R5: For ADD, ADC, SUB, SBB, AND, OR, XOR, CMP and DAA, Z is set when the result is all zeros and S equals its top bit. P is set when the result holds an even number of ones. For CMP the result is the difference.
- R6: RLC rotates A left, with the old top bit entering both bit 0 and CY. RRC rotates right, with the old bit 0 entering both the top bit and CY.
- R7: RAL shifts A left, with the old carry entering bit 0 and the old top bit going to CY. RAR shifts right, with the old carry entering the top bit and the old bit 0 going to CY.
- R8: The four rotates leave S, Z, AC and P equal to the flag input.
- R9: CMA returns the bitwise inverse of A and leaves all five flags equal to the flag input.
- R10: STC forces CY to 1 and CMC inverts CY. Both leave the accumulator and the other four flags unchanged.
- R11: DAA adds 6 to the low nibble when that nibble exceeds 9 or the AC input is set. AC out is the carry out of bit 3 caused by that correction.
- R12: DAA then tests the high nibble, after the low correction, and adds 6 to it when it exceeds 9 or the CY input is set. CY out is 1 when that high correction is applied and is otherwise the CY input.
- R13: With REG_OUT=1 the outputs change one clock after the inputs and are cleared to zero while `rst` is high. With REG_OUT=0 they follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output registers |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| op_i | input | 4 | Operation code |
| acc_i | input | DATA_W | Accumulator value |
| opnd_i | input | DATA_W | Second operand |
| flags_i | input | 5 | Incoming flags {S,Z,AC,P,CY} |
| acc_o | output | DATA_W | New accumulator value |
| flags_o | output | 5 | New flags {S,Z,AC,P,CY} |

## Verification
The bench builds two copies with the default eight-bit width: one with REG_OUT=1 and one with REG_OUT=0. Both are driven from the same stimulus. The registered copy brings the one-cycle latency and the reset clearing into reach. The combinational copy shows each result within its own cycle. The eight-bit width lets hand-computed BCD vectors exercise every path of the two-nibble correction: low only, high only, and a low correction that pushes the high nibble past nine.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;

  localparam int OP_W   = 4;
  localparam int FLAG_W = 5;
  localparam int NIB_W  = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_CMP = 4'd7,
    OP_CMA = 4'd8,
    OP_STC = 4'd9,
    OP_CMC = 4'd10,
    OP_RLC = 4'd11,
    OP_RRC = 4'd12,
    OP_RAL = 4'd13,
    OP_RAR = 4'd14,
    OP_DAA = 4'd15
  } alu_op_e;

  // Flag word, most significant field first: sign, zero, half carry, parity, carry.
  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

endpackage

// File: rtl/acc_adder.sv
`timescale 1ns/1ps
// Shared add/subtract path. Subtraction is done as A + ~B + ~borrow,
// and both carries are inverted so that they read as borrows.
module acc_adder
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cy_o,
  output logic              ac_o
);

  logic [DATA_W-1:0] b_eff;
  logic              c_eff;
  logic [DATA_W:0]   full_sum;
  logic [NIB_W:0]    low_sum;

  always_comb begin
    b_eff    = sub_i ? ~b_i : b_i;
    c_eff    = sub_i ? ~cin_i : cin_i;
    full_sum = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
    low_sum  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
             + {{NIB_W{1'b0}}, c_eff};
  end

  assign sum_o = full_sum[DATA_W-1:0];
  assign cy_o  = full_sum[DATA_W] ^ sub_i;
  assign ac_o  = low_sum[NIB_W] ^ sub_i;

endmodule

// File: rtl/acc_logic.sv
`timescale 1ns/1ps
// Bitwise operations, rotates and carry-only operations.
module acc_logic
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cy_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o
);

  localparam int TOP = DATA_W - 1;

  always_comb begin
    res_o = a_i;
    cy_o  = cy_i;
    unique case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_CMA: res_o = ~a_i;
      OP_STC: cy_o  = 1'b1;
      OP_CMC: cy_o  = ~cy_i;
      OP_RLC: begin
        res_o = {a_i[TOP-1:0], a_i[TOP]};
        cy_o  = a_i[TOP];
      end
      OP_RRC: begin
        res_o = {a_i[0], a_i[TOP:1]};
        cy_o  = a_i[0];
      end
      OP_RAL: begin
        res_o = {a_i[TOP-1:0], cy_i};
        cy_o  = a_i[TOP];
      end
      OP_RAR: begin
        res_o = {cy_i, a_i[TOP:1]};
        cy_o  = a_i[0];
      end
      default: begin
        res_o = a_i;
        cy_o  = cy_i;
      end
    endcase
  end

endmodule

// File: rtl/acc_decadj.sv
`timescale 1ns/1ps
// Packed-BCD correction. Digits are corrected from the least significant
// upward, and each test sees the value left by the corrections below it.
// The lowest digit also honours the half-carry flag, the highest digit honours carry.
module acc_decadj
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic              ac_i,
  input  logic              cy_i,
  output logic [DATA_W-1:0] res_o,
  output logic              ac_o,
  output logic              cy_o
);

  localparam int DIGITS = DATA_W / NIB_W;
  localparam logic [DATA_W-1:0] SIX = DATA_W'(6);

  logic [DATA_W-1:0] work;
  logic              low_fix;
  logic              top_fix;
  logic [NIB_W:0]    low_sum;

  always_comb begin
    work    = a_i;
    low_fix = 1'b0;
    top_fix = 1'b0;
    for (int d = 0; d < DIGITS; d++) begin
      logic force_fix;
      logic apply;
      force_fix = ((d == 0) && ac_i) || ((d == DIGITS - 1) && cy_i);
      apply     = (work[d*NIB_W +: NIB_W] > 4'd9) || force_fix;
      if (apply) begin
        work = work + (SIX << (d * NIB_W));
      end
      if (d == 0)          low_fix = apply;
      if (d == DIGITS - 1) top_fix = apply;
    end
    low_sum = {1'b0, a_i[NIB_W-1:0]} + 5'd6;
  end

  assign res_o = work;
  assign ac_o  = low_fix & low_sum[NIB_W];
  assign cy_o  = top_fix | cy_i;

endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [FLAG_W-1:0] flags_o
);

  alu_op_e           op;
  flags_t            fin;
  flags_t            fnext;
  logic [DATA_W-1:0] res_next;
  logic [DATA_W-1:0] szp_src;

  logic              add_sub;
  logic              add_cin;
  logic [DATA_W-1:0] add_sum;
  logic              add_cy;
  logic              add_ac;

  logic [DATA_W-1:0] lg_res;
  logic              lg_cy;

  logic [DATA_W-1:0] da_res;
  logic              da_ac;
  logic              da_cy;

  assign op  = alu_op_e'(op_i);
  assign fin = flags_t'(flags_i);

  assign add_sub = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
  assign add_cin = fin.cy && ((op == OP_ADC) || (op == OP_SBB));

  acc_adder #(.DATA_W(DATA_W)) u_add (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .cin_i (add_cin),
    .sub_i (add_sub),
    .sum_o (add_sum),
    .cy_o  (add_cy),
    .ac_o  (add_ac)
  );

  acc_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i  (op),
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .cy_i  (fin.cy),
    .res_o (lg_res),
    .cy_o  (lg_cy)
  );

  acc_decadj #(.DATA_W(DATA_W)) u_daa (
    .a_i   (acc_i),
    .ac_i  (fin.ac),
    .cy_i  (fin.cy),
    .res_o (da_res),
    .ac_o  (da_ac),
    .cy_o  (da_cy)
  );

  always_comb begin
    logic upd_szp;
    res_next = acc_i;
    fnext    = fin;
    szp_src  = acc_i;
    upd_szp  = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        res_next = add_sum;
        szp_src  = add_sum;
        fnext.cy = add_cy;
        fnext.ac = add_ac;
        upd_szp  = 1'b1;
      end
      OP_CMP: begin
        szp_src  = add_sum;
        fnext.cy = add_cy;
        fnext.ac = add_ac;
        upd_szp  = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_next = lg_res;
        szp_src  = lg_res;
        fnext.cy = 1'b0;
        fnext.ac = 1'b0;
        upd_szp  = 1'b1;
      end
      OP_DAA: begin
        res_next = da_res;
        szp_src  = da_res;
        fnext.cy = da_cy;
        fnext.ac = da_ac;
        upd_szp  = 1'b1;
      end
      default: begin
        res_next = lg_res;
        fnext.cy = lg_cy;
      end
    endcase
    if (upd_szp) begin
      fnext.s = szp_src[DATA_W-1];
      fnext.z = (szp_src == '0);
      fnext.p = ~^szp_src;
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [DATA_W-1:0] acc_q;
      logic [FLAG_W-1:0] flags_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          acc_q   <= '0;
          flags_q <= '0;
        end else begin
          acc_q   <= res_next;
          flags_q <= fnext;
        end
      end
      assign acc_o   = acc_q;
      assign flags_o = flags_q;
    end else begin : g_comb
      assign acc_o   = res_next;
      assign flags_o = fnext;
    end
  endgenerate

endmodule

// File: rtl/acc_alu_chk.sv
`timescale 1ns/1ps
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [DATA_W-1:0] acc_o,
  input  logic [FLAG_W-1:0] flags_o
);

  logic [OP_W-1:0]   op_q;
  logic [DATA_W-1:0] acc_q;
  logic [FLAG_W-1:0] fl_q;
  logic              vld;

  always_ff @(posedge clk) begin
    if (rst) vld <= 1'b0;
    else     vld <= 1'b1;
  end

  generate
    if (REG_OUT) begin : g_align
      always_ff @(posedge clk) begin
        op_q  <= op_i;
        acc_q <= acc_i;
        fl_q  <= flags_i;
      end
    end else begin : g_direct
      assign op_q  = op_i;
      assign acc_q = acc_i;
      assign fl_q  = flags_i;
    end
  endgenerate

  logic is_logic, is_rot, is_szp;
  assign is_logic = (op_q == OP_AND) || (op_q == OP_OR) || (op_q == OP_XOR);
  assign is_rot   = (op_q == OP_RLC) || (op_q == OP_RRC) ||
                    (op_q == OP_RAL) || (op_q == OP_RAR);
  assign is_szp   = (op_q <= OP_XOR) || (op_q == OP_DAA);

  assert_cmp_keeps_acc_R3: assert property (@(posedge clk) disable iff (rst || !vld)
    (op_q == OP_CMP) |-> (acc_o == acc_q));

  assert_logic_clears_carries_R4: assert property (@(posedge clk) disable iff (rst || !vld)
    is_logic |-> (!flags_o[0] && !flags_o[2]));

  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (rst || !vld)
    is_szp |-> (flags_o[3] == (acc_o == '0)));

  assert_parity_flag_R5: assert property (@(posedge clk) disable iff (rst || !vld)
    is_szp |-> (flags_o[1] == ~^acc_o));

  assert_rotate_keeps_flags_R8: assert property (@(posedge clk) disable iff (rst || !vld)
    is_rot |-> (flags_o[4:1] == fl_q[4:1]));

  assert_cma_inverts_R9: assert property (@(posedge clk) disable iff (rst || !vld)
    (op_q == OP_CMA) |-> ((acc_o == ~acc_q) && (flags_o == fl_q)));

  assert_stc_sets_cy_R10: assert property (@(posedge clk) disable iff (rst || !vld)
    (op_q == OP_STC) |-> (flags_o[0] && (acc_o == acc_q)));

  assert_daa_keeps_cy_R12: assert property (@(posedge clk) disable iff (rst || !vld)
    ((op_q == OP_DAA) && fl_q[0]) |-> flags_o[0]);

endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .op_i    (op_i),
  .acc_i   (acc_i),
  .flags_i (flags_i),
  .acc_o   (acc_o),
  .flags_o (flags_o)
);

// File: tb/acc_alu_tb_top.sv
`timescale 1ns/1ps
module acc_alu_tb_top;
  import acc_alu_pkg::*;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   op  = '0;
  logic [W-1:0] acc = '0;
  logic [W-1:0] opnd = '0;
  logic [4:0]   fl  = '0;
  logic [W-1:0] acc_r, acc_c;
  logic [4:0]   fl_r, fl_c;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  acc_alu #(.DATA_W(W), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .op_i(op), .acc_i(acc), .opnd_i(opnd),
    .flags_i(fl), .acc_o(acc_r), .flags_o(fl_r));

  acc_alu #(.DATA_W(W), .REG_OUT(1'b0)) dut_c (
    .clk(clk), .rst(rst), .op_i(op), .acc_i(acc), .opnd_i(opnd),
    .flags_i(fl), .acc_o(acc_c), .flags_o(fl_c));

  task automatic check(string req, string what, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // Drive one vector; check the combinational copy in-cycle, the registered copy after the edge.
  task automatic run(string req, alu_op_e o, logic [7:0] a, logic [7:0] b,
                     logic [4:0] f, logic [7:0] ea, logic [4:0] ef);
    @(negedge clk);
    op = o; acc = a; opnd = b; fl = f;
    #1;
    check(req, "comb acc", acc_c, ea);
    check(req, "comb flags", {3'b0, fl_c}, {3'b0, ef});
    @(posedge clk); #1;
    check(req, "reg acc", acc_r, ea);
    check(req, "reg flags", {3'b0, fl_r}, {3'b0, ef});
  endtask

  task automatic t_reset();
    rst = 1'b1;
    op = OP_ADD; acc = 8'h77; opnd = 8'h11; fl = 5'b11111;
    repeat (3) @(posedge clk);
    #1;
    check("R13", "reset acc", acc_r, 8'h00);
    check("R13", "reset flags", {3'b0, fl_r}, 8'h00);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_add();
    run("R1", OP_ADD, 8'h3A, 8'h28, 5'b00000, 8'h62, 5'b00100);
    run("R1", OP_ADC, 8'hFF, 8'h00, 5'b00001, 8'h00, 5'b01111);
    run("R1", OP_ADD, 8'h80, 8'h80, 5'b00001, 8'h00, 5'b01011);
  endtask

  task automatic t_sub();
    run("R2", OP_SUB, 8'h10, 8'h01, 5'b00000, 8'h0F, 5'b00110);
    run("R2", OP_SBB, 8'h05, 8'h05, 5'b00001, 8'hFF, 5'b10111);
    run("R2", OP_SUB, 8'h05, 8'h05, 5'b00001, 8'h00, 5'b01010);
  endtask

  task automatic t_cmp();
    run("R3", OP_CMP, 8'h20, 8'h30, 5'b00000, 8'h20, 5'b10011);
    run("R3", OP_CMP, 8'h42, 8'h42, 5'b00001, 8'h42, 5'b01010);
  endtask

  task automatic t_logic();
    run("R4", OP_AND, 8'hF0, 8'h3C, 5'b00101, 8'h30, 5'b00010);
    run("R4", OP_OR,  8'h01, 8'h80, 5'b00001, 8'h81, 5'b10010);
  endtask

  task automatic t_szp();
    run("R5", OP_XOR, 8'h55, 8'h55, 5'b10000, 8'h00, 5'b01010);
    run("R5", OP_OR,  8'h07, 8'h00, 5'b01010, 8'h07, 5'b00000);
  endtask

  task automatic t_rot();
    run("R6", OP_RLC, 8'h81, 8'h00, 5'b10100, 8'h03, 5'b10101);
    run("R6", OP_RRC, 8'h01, 8'h00, 5'b01010, 8'h80, 5'b01011);
    run("R7", OP_RAL, 8'h80, 8'h00, 5'b00000, 8'h00, 5'b00001);
    run("R7", OP_RAR, 8'h02, 8'h00, 5'b11111, 8'h81, 5'b11110);
    run("R8", OP_RAL, 8'h40, 8'hFF, 5'b01110, 8'h80, 5'b01110);
  endtask

  task automatic t_cma();
    run("R9", OP_CMA, 8'h5A, 8'h00, 5'b10101, 8'hA5, 5'b10101);
  endtask

  task automatic t_carry();
    run("R10", OP_STC, 8'h12, 8'h34, 5'b00000, 8'h12, 5'b00001);
    run("R10", OP_CMC, 8'h12, 8'h34, 5'b01011, 8'h12, 5'b01010);
  endtask

  task automatic t_daa_low();
    run("R11", OP_DAA, 8'h15, 8'h00, 5'b00100, 8'h1B, 5'b00010);
    run("R11", OP_DAA, 8'h8F, 8'h00, 5'b00000, 8'h95, 5'b10110);
    run("R11", OP_DAA, 8'h99, 8'h00, 5'b00000, 8'h99, 5'b10010);
  endtask

  task automatic t_daa_high();
    run("R12", OP_DAA, 8'h9A, 8'h00, 5'b00000, 8'h00, 5'b01111);
    run("R12", OP_DAA, 8'h25, 8'h00, 5'b00001, 8'h85, 5'b10001);
    run("R12", OP_DAA, 8'h99, 8'h00, 5'b00001, 8'hF9, 5'b10011);
  endtask

  task automatic t_latency();
    // Registered copy must still show the previous result before the edge.
    run("R13", OP_ADD, 8'h01, 8'h01, 5'b00000, 8'h02, 5'b00000);
    @(negedge clk);
    op = OP_ADD; acc = 8'h10; opnd = 8'h20; fl = 5'b00000;
    #1;
    check("R13", "comb same cycle", acc_c, 8'h30);
    check("R13", "reg holds old", acc_r, 8'h02);
    @(posedge clk); #1;
    check("R13", "reg after edge", acc_r, 8'h30);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R13", "mid-run reset acc", acc_r, 8'h00);
    check("R13", "mid-run reset flags", {3'b0, fl_r}, 8'h00);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_cmp();
    t_logic();
    t_szp();
    t_rot();
    t_cma();
    t_carry();
    t_daa_low();
    t_daa_high();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule